// File: doc/BRIEF.md
# Eight-lane complex upconversion oscillator

This block is a numerically controlled oscillator that produces several carrier samples per system clock, eight by default. Each clock it takes one complex baseband sample, typically the sum of two slower tone generators, and holds it unchanged across every lane. Each lane multiplies it by its own point of a complex carrier, exp(i·θ), where θ follows a 48-bit phase accumulator plus a 16-bit phase offset. Sine and cosine come from a quarter-wave table of 17 points with linear interpolation between them.

Each lane's complex product is brought out as its own pair of ports, so that a neighbouring channel can use it. The real output of each lane is a 16-bit offset word plus, under two enable bits, the real part of the product and the imaginary part supplied by the paired channel for that lane. The sum saturates to the signed 16-bit range. All inputs presented in one clock reach the outputs together after a fixed latency of three clocks.

Top module: `supersampled_upconverter`

## Requirements
- R1: While `rst_n` is low every output lane reads 0 and the phase accumulator is held at 0. The first clock after reset uses an accumulator value of 0.
- R2: The carrier phase of lane k is acc + k·F + P·2^32, taken modulo 2^48. The angle of that phase is 2π·phase/2^48, and only its upper 16 bits address the sine table.
- R3: The accumulator advances by LANES·F every clock, modulo 2^48. A new F or P applies to all lanes in the clock it is presented, with no lane lagging another.
- R4: The baseband sample (I, Q) is shared by all lanes. z_re ≈ I·cosθ − Q·sinθ and z_im ≈ I·sinθ + Q·cosθ, each within ±128 LSB of the exact value.
- R5: Every input presented before clock edge n appears on the outputs after edge n+2, which is a latency of three clocks.
- R6: out = offset + en_re·z_re + en_buddy·buddy_im[k], lane by lane. With en_re low the output is exact.
- R7: z_re, z_im and out saturate to the range −32768..32767 and do not wrap.
- R8: With F = 0 every lane carries the same phase, so all lanes of z_re and of z_im are equal.
- R9: A zero baseband sample yields z_re = z_im = 0 exactly on every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_i | input | 48 | Carrier frequency word F, in turns·2^48 per sample |
| phase_i | input | 16 | Carrier phase offset P, in turns·2^16 |
| bb_re_i | input | 16 | Baseband real part I, signed |
| bb_im_i | input | 16 | Baseband imaginary part Q, signed |
| buddy_im_i | input | 128 | Imaginary part of the paired channel's product, lane k at bits 16k+15:16k |
| offset_i | input | 16 | Signed offset added to every lane |
| en_re_i | input | 1 | Adds the real part of the own product |
| en_buddy_i | input | 1 | Adds the paired channel's imaginary part |
| out_o | output | 128 | Real output, lane k at bits 16k+15:16k |
| z_re_o | output | 128 | Real part of the product per lane |
| z_im_o | output | 128 | Imaginary part of the product per lane |

## Verification
The bench builds the block with its default parameters: eight lanes and a 48-bit frequency word. With this setting the stride 8·F wraps the accumulator after a few dozen clocks when large frequency words are used, so the modulo arithmetic of R2 and R3 is exercised. A step of 2^45 per sample turns each lane 45° from its neighbour, which visits every quadrant of the table within a single clock. Full-scale baseband and offset-plus-buddy sums drive the saturation of R7 to both rails, and the paths with en_re low are compared exactly.

// File: rtl/upc_pkg.sv
package upc_pkg;

    localparam int SMP_W   = 16;
    localparam int SMP_MAX = (1 << (SMP_W - 1)) - 1;
    localparam int SMP_MIN = -(1 << (SMP_W - 1));
    localparam int WIDE_W  = 2 * SMP_W + 2;

    typedef logic signed [SMP_W-1:0]  smp_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    typedef struct packed {
        smp_t bre;
        smp_t bim;
        smp_t ofs;
        logic en_re;
        logic en_bud;
    } side_t;

    // sin(i*pi/32) scaled to 32767, i = 0..16; beyond 16 the peak is returned
    function automatic int quarter_tab(input int i);
        case (i)
            0:       return 0;
            1:       return 3212;
            2:       return 6393;
            3:       return 9512;
            4:       return 12539;
            5:       return 15446;
            6:       return 18204;
            7:       return 20787;
            8:       return 23170;
            9:       return 25329;
            10:      return 27245;
            11:      return 28898;
            12:      return 30273;
            13:      return 31356;
            14:      return 32137;
            15:      return 32609;
            default: return 32767;
        endcase
    endfunction

    // sine of a 16-bit phase: quadrant fold, 17-point table, 8-bit interpolation
    function automatic smp_t sin_lookup(input logic [15:0] ph);
        logic [14:0] pos;
        int idx;
        int fr;
        int lo;
        int hi;
        int v;
        pos = ph[14] ? (15'd16384 - {1'b0, ph[13:0]}) : {1'b0, ph[13:0]};
        idx = int'(pos[14:10]);
        fr  = int'(pos[9:2]);
        lo  = quarter_tab(idx);
        hi  = quarter_tab(idx + 1);
        v   = lo + (((hi - lo) * fr) >>> 8);
        if (ph[15]) begin
            v = -v;
        end
        return smp_t'(v);
    endfunction

    function automatic smp_t sat_smp(input wide_t x);
        if (x > wide_t'(SMP_MAX)) begin
            return smp_t'(SMP_MAX);
        end
        if (x < wide_t'(SMP_MIN)) begin
            return smp_t'(SMP_MIN);
        end
        return smp_t'(x);
    endfunction

endpackage

// File: rtl/upc_delay.sv
module upc_delay #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= '0;
            end
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/upc_phase_gen.sv
module upc_phase_gen #(
    parameter int LANES = 8,
    parameter int FW    = 48,
    parameter int PW    = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [FW-1:0]            freq,
    input  logic [PW-1:0]            phase,
    output logic [LANES-1:0][PW-1:0] lane_ph
);

    localparam int SH = FW - PW;

    logic [FW-1:0] acc;
    logic [FW-1:0] stride;
    logic [FW-1:0] ofs_full;

    assign stride   = freq * FW'(LANES);
    assign ofs_full = {phase, {SH{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= acc + stride;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [FW-1:0] full;
        assign full = acc + freq * FW'(k) + ofs_full;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_ph[k] <= '0;
            end else begin
                lane_ph[k] <= full[FW-1 -: PW];
            end
        end
    end

endmodule

// File: rtl/upc_sincos.sv
module upc_sincos
    import upc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LANES-1:0][15:0] lane_ph,
    output smp_t                  sin_q [LANES],
    output smp_t                  cos_q [LANES]
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sin_q[k] <= '0;
                cos_q[k] <= '0;
            end else begin
                sin_q[k] <= sin_lookup(lane_ph[k]);
                cos_q[k] <= sin_lookup(lane_ph[k] + 16'h4000);
            end
        end
    end

endmodule

// File: rtl/upc_mix_out.sv
module upc_mix_out
    import upc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  smp_t  sin_q [LANES],
    input  smp_t  cos_q [LANES],
    input  side_t side,
    input  smp_t  buddy [LANES],
    output smp_t  out_q [LANES],
    output smp_t  zr_q  [LANES],
    output smp_t  zi_q  [LANES]
);

    localparam int PROD_W = 2 * SMP_W + 1;
    localparam int FRAC   = SMP_W - 1;

    logic signed [PROD_W-1:0] bre_x;
    logic signed [PROD_W-1:0] bim_x;

    assign bre_x = PROD_W'(side.bre);
    assign bim_x = PROD_W'(side.bim);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [PROD_W-1:0] c_x;
        logic signed [PROD_W-1:0] s_x;
        logic signed [PROD_W-1:0] pr_re;
        logic signed [PROD_W-1:0] pr_im;
        smp_t                     zr_n;
        smp_t                     zi_n;
        wide_t                    sum;

        assign c_x   = PROD_W'(cos_q[k]);
        assign s_x   = PROD_W'(sin_q[k]);
        assign pr_re = bre_x * c_x - bim_x * s_x;
        assign pr_im = bre_x * s_x + bim_x * c_x;
        assign zr_n  = sat_smp(WIDE_W'(pr_re >>> FRAC));
        assign zi_n  = sat_smp(WIDE_W'(pr_im >>> FRAC));
        assign sum   = WIDE_W'(side.ofs)
                     + (side.en_re  ? WIDE_W'(zr_n)     : '0)
                     + (side.en_bud ? WIDE_W'(buddy[k]) : '0);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q[k] <= '0;
                zr_q[k]  <= '0;
                zi_q[k]  <= '0;
            end else begin
                out_q[k] <= sat_smp(sum);
                zr_q[k]  <= zr_n;
                zi_q[k]  <= zi_n;
            end
        end
    end

endmodule

// File: rtl/supersampled_upconverter.sv
module supersampled_upconverter
    import upc_pkg::*;
#(
    parameter int LANES = 8,
    parameter int FW    = 48,
    parameter int PW    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FW-1:0]          freq_i,
    input  logic [PW-1:0]          phase_i,
    input  logic [SMP_W-1:0]       bb_re_i,
    input  logic [SMP_W-1:0]       bb_im_i,
    input  logic [LANES*SMP_W-1:0] buddy_im_i,
    input  logic [SMP_W-1:0]       offset_i,
    input  logic                   en_re_i,
    input  logic                   en_buddy_i,
    output logic [LANES*SMP_W-1:0] out_o,
    output logic [LANES*SMP_W-1:0] z_re_o,
    output logic [LANES*SMP_W-1:0] z_im_o
);

    localparam int ALIGN  = 2;
    localparam int SIDE_W = $bits(side_t);
    localparam int BUD_W  = LANES * SMP_W;

    logic [LANES-1:0][15:0] lane_ph;
    smp_t                   sin_q [LANES];
    smp_t                   cos_q [LANES];
    side_t                  side_in;
    side_t                  side_d;
    logic [BUD_W-1:0]       buddy_d;
    smp_t                   buddy [LANES];
    smp_t                   out_q [LANES];
    smp_t                   zr_q  [LANES];
    smp_t                   zi_q  [LANES];

    assign side_in = '{bre: smp_t'(bb_re_i), bim: smp_t'(bb_im_i),
                       ofs: smp_t'(offset_i), en_re: en_re_i,
                       en_bud: en_buddy_i};

    upc_phase_gen #(.LANES(LANES), .FW(FW), .PW(PW)) phase_i0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .freq    (freq_i),
        .phase   (phase_i),
        .lane_ph (lane_ph)
    );

    upc_sincos #(.LANES(LANES)) sincos_i0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_ph (lane_ph),
        .sin_q   (sin_q),
        .cos_q   (cos_q)
    );

    upc_delay #(.W(SIDE_W), .STAGES(ALIGN)) side_dly_i0 (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (side_in),
        .q     (side_d)
    );

    upc_delay #(.W(BUD_W), .STAGES(ALIGN)) buddy_dly_i0 (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (buddy_im_i),
        .q     (buddy_d)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign buddy[k]                   = smp_t'(buddy_d[k*SMP_W +: SMP_W]);
        assign out_o [k*SMP_W +: SMP_W]   = out_q[k];
        assign z_re_o[k*SMP_W +: SMP_W]   = zr_q[k];
        assign z_im_o[k*SMP_W +: SMP_W]   = zi_q[k];
    end

    upc_mix_out #(.LANES(LANES)) mix_i0 (
        .clk   (clk),
        .rst_n (rst_n),
        .sin_q (sin_q),
        .cos_q (cos_q),
        .side  (side_d),
        .buddy (buddy),
        .out_q (out_q),
        .zr_q  (zr_q),
        .zi_q  (zi_q)
    );

endmodule

// File: rtl/upc_checker.sv
module upc_checker #(
    parameter int LANES = 8,
    parameter int FW    = 48
) (
    input logic                clk,
    input logic                rst_n,
    input logic [FW-1:0]       freq_i,
    input logic [15:0]         bb_re_i,
    input logic [15:0]         bb_im_i,
    input logic [LANES*16-1:0] buddy_im_i,
    input logic [15:0]         offset_i,
    input logic                en_re_i,
    input logic                en_buddy_i,
    input logic [LANES*16-1:0] out_o,
    input logic [LANES*16-1:0] z_re_o,
    input logic [LANES*16-1:0] z_im_o
);

    logic [1:0] since;
    logic       live;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0;
        end else if (since != 2'd3) begin
            since <= since + 2'd1;
        end
    end

    assign live = (since == 2'd3);

    // R6 with both enables low the offset passes to every lane (R5 latency)
    a_r6_offset_only: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(!en_re_i && !en_buddy_i, 3)
        |-> out_o == {LANES{$past(offset_i, 3)}});

    // R9 zero baseband gives exactly zero product on all lanes
    a_r9_zero_product: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(bb_re_i == 16'd0 && bb_im_i == 16'd0, 3)
        |-> z_re_o == '0 && z_im_o == '0);

    // R8 zero frequency word makes every lane equal
    a_r8_lanes_equal: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(freq_i == '0, 3)
        |-> z_re_o == {LANES{z_re_o[15:0]}} && z_im_o == {LANES{z_im_o[15:0]}});

    // R7 positive overflow of offset plus buddy clamps to the top rail
    a_r7_clamp_high: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(!en_re_i && en_buddy_i && !offset_i[15] && !buddy_im_i[15]
                      && ({1'b0, offset_i} + {1'b0, buddy_im_i[15:0]}) > 17'd32767, 3)
        |-> out_o[15:0] == 16'h7FFF);

    // R7 negative overflow clamps to the bottom rail
    a_r7_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
        live && $past(!en_re_i && en_buddy_i && offset_i[15] && buddy_im_i[15]
                      && ({1'b1, offset_i} + {1'b1, buddy_im_i[15:0]}) < 17'h18000, 3)
        |-> out_o[15:0] == 16'h8000);

endmodule

bind supersampled_upconverter upc_checker #(.LANES(LANES), .FW(FW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_i     (freq_i),
    .bb_re_i    (bb_re_i),
    .bb_im_i    (bb_im_i),
    .buddy_im_i (buddy_im_i),
    .offset_i   (offset_i),
    .en_re_i    (en_re_i),
    .en_buddy_i (en_buddy_i),
    .out_o      (out_o),
    .z_re_o     (z_re_o),
    .z_im_o     (z_im_o)
);

// File: tb/supersampled_upconverter_tb_top.sv
`timescale 1ns/1ps
module supersampled_upconverter_tb_top;

    localparam int  L    = 8;
    localparam int  TOL  = 128;
    localparam real PI   = 3.14159265358979;
    localparam real TWO48 = 281474976710656.0;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [47:0]       freq_i;
    logic [15:0]       phase_i;
    logic [15:0]       bb_re_i;
    logic [15:0]       bb_im_i;
    logic [L*16-1:0]   buddy_im_i;
    logic [15:0]       offset_i;
    logic              en_re_i;
    logic              en_buddy_i;
    logic [L*16-1:0]   out_o;
    logic [L*16-1:0]   z_re_o;
    logic [L*16-1:0]   z_im_o;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;
    logic [47:0] acc_m = '0;

    logic [L*16-1:0] q_out [$];
    logic [L*16-1:0] q_zr  [$];
    logic [L*16-1:0] q_zi  [$];
    int              q_tolo [$];
    int              q_tolz [$];
    string           q_tag  [$];

    always #10 clk = ~clk;

    supersampled_upconverter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .freq_i     (freq_i),
        .phase_i    (phase_i),
        .bb_re_i    (bb_re_i),
        .bb_im_i    (bb_im_i),
        .buddy_im_i (buddy_im_i),
        .offset_i   (offset_i),
        .en_re_i    (en_re_i),
        .en_buddy_i (en_buddy_i),
        .out_o      (out_o),
        .z_re_o     (z_re_o),
        .z_im_o     (z_im_o)
    );

    function automatic int clamp16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic cmp(input string tag, input string what, input int lane,
                       input int act, input int exp, input int tol);
        n_chk++;
        if (act - exp > tol || exp - act > tol) begin
            n_bad++;
            $display("FAIL %s %s lane %0d: actual %0d expected %0d (tol %0d)",
                     tag, what, lane, act, exp, tol);
        end
    endtask

    task automatic monitor_pop();
        logic [L*16-1:0] eo;
        logic [L*16-1:0] er;
        logic [L*16-1:0] ei;
        int              to;
        int              tz;
        string           tg;
        if (q_tag.size() == 3) begin
            eo = q_out.pop_front();
            er = q_zr.pop_front();
            ei = q_zi.pop_front();
            to = q_tolo.pop_front();
            tz = q_tolz.pop_front();
            tg = q_tag.pop_front();
            for (int k = 0; k < L; k++) begin
                cmp(tg, "out", k, int'($signed(out_o[k*16 +: 16])),  int'($signed(eo[k*16 +: 16])), to);
                cmp(tg, "z_re", k, int'($signed(z_re_o[k*16 +: 16])), int'($signed(er[k*16 +: 16])), tz);
                cmp(tg, "z_im", k, int'($signed(z_im_o[k*16 +: 16])), int'($signed(ei[k*16 +: 16])), tz);
            end
        end
    endtask

    // driver: check the item due now, drive the next vector, queue its expectation (R5)
    task automatic step(input logic [47:0] f, input logic [15:0] p,
                        input int bi, input int bq, input int u,
                        input bit b, input bit c,
                        input int bud0, input int budstep, input string tag);
        logic [L*16-1:0] eo;
        logic [L*16-1:0] er;
        logic [L*16-1:0] ei;
        @(negedge clk);
        monitor_pop();
        freq_i     = f;
        phase_i    = p;
        bb_re_i    = 16'(bi);
        bb_im_i    = 16'(bq);
        offset_i   = 16'(u);
        en_re_i    = b;
        en_buddy_i = c;
        for (int k = 0; k < L; k++) begin
            logic [47:0] ph;
            real         th;
            int          zr;
            int          zi;
            int          bd;
            ph = acc_m + f * 48'(k) + {p, 32'h0};
            th = 2.0 * PI * real'(ph) / TWO48;
            zr = clamp16(int'(real'(bi) * $cos(th) - real'(bq) * $sin(th)));
            zi = clamp16(int'(real'(bi) * $sin(th) + real'(bq) * $cos(th)));
            bd = clamp16(bud0 + k * budstep);
            buddy_im_i[k*16 +: 16] = 16'(bd);
            er[k*16 +: 16] = 16'(zr);
            ei[k*16 +: 16] = 16'(zi);
            eo[k*16 +: 16] = 16'(clamp16(u + (b ? zr : 0) + (c ? bd : 0)));
        end
        q_out.push_back(eo);
        q_zr.push_back(er);
        q_zi.push_back(ei);
        q_tolo.push_back(b ? TOL : 0);
        q_tolz.push_back((bi == 0 && bq == 0) ? 0 : TOL);
        q_tag.push_back(tag);
        acc_m = acc_m + f * 48'(L);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n      = 1'b0;
        freq_i     = 48'h1234_5678_9ABC;
        phase_i    = 16'h1111;
        bb_re_i    = 16'd5000;
        bb_im_i    = 16'd3000;
        buddy_im_i = '1;
        offset_i   = 16'd777;
        en_re_i    = 1'b1;
        en_buddy_i = 1'b1;
        repeat (4) @(negedge clk);
        // R1 outputs are zero while reset is held, whatever the inputs
        for (int k = 0; k < L; k++) begin
            cmp("R1", "out", k, int'($signed(out_o[k*16 +: 16])), 0, 0);
            cmp("R1", "z_re", k, int'($signed(z_re_o[k*16 +: 16])), 0, 0);
        end
        rst_n      = 1'b1;
        freq_i     = '0;
        phase_i    = '0;
        bb_re_i    = '0;
        bb_im_i    = '0;
        buddy_im_i = '0;
        offset_i   = '0;
        en_re_i    = 1'b0;
        en_buddy_i = 1'b0;

        // R1 R2 R3 first tone starts from a zero accumulator
        for (int i = 0; i < 6; i++)
            step(48'h0123_4567_89AB, 16'h0000, 12000, -7000, 0, 1'b1, 1'b0, 0, 0, "R1 R3 R4");
        // R4 R8 zero frequency: every lane equal, z close to baseband
        for (int i = 0; i < 6; i++)
            step(48'h0, 16'h0000, 10000, 0, 1000, 1'b1, 1'b0, 0, 0, "R4 R8");
        // R2 quarter-turn offset rotates I into Q
        for (int i = 0; i < 6; i++)
            step(48'h0, 16'h4000, 10000, 0, -200, 1'b1, 1'b0, 0, 0, "R2 R8");
        // R9 zero baseband with a running carrier and buddy path
        for (int i = 0; i < 8; i++)
            step(48'h0F00_0000_0001, 16'h2345, 0, 0, -500, 1'b1, 1'b1, 100, 37, "R9 R6");
        // R6 both enables low: output equals offset exactly
        for (int i = 0; i < 8; i++)
            step(48'h0333_0000_0000, 16'h0000, 20000, 15000, 1234 - i, 1'b0, 1'b0, 9999, 1, "R6");
        // R6 buddy only, exact sum
        for (int i = 0; i < 6; i++)
            step(48'h0010_0000_0000, 16'h0100, 3000, 3000, -4000, 1'b0, 1'b1, -3000, 911, "R6");
        // R2 R3 eighth-turn per sample visits every quadrant in one clock
        for (int i = 0; i < 12; i++)
            step(48'h2000_0000_0000, 16'(i * 1500), 15000, 9000, 0, 1'b1, 1'b0, 0, 0, "R2 R3");
        // R3 frequency word changes every clock, all lanes follow at once
        for (int i = 0; i < 20; i++)
            step((i % 2 == 0) ? 48'h0777_0000_1234 : 48'hFA00_0000_0000,
                 16'h0000, -9000, 11000, 300, 1'b1, 1'b1, 50, -20, "R3");
        // R3 accumulator wraps with a large word over many clocks
        for (int i = 0; i < 40; i++)
            step(48'h6A09_E667_F3BC, 16'hC000, 8000, 8000, 0, 1'b1, 1'b0, 0, 0, "R2 R3");
        // R7 offset plus buddy clamps at the top rail
        for (int i = 0; i < 5; i++)
            step(48'h0, 16'h0000, 0, 0, 30000, 1'b0, 1'b1, 30000, 100, "R7");
        // R7 bottom rail
        for (int i = 0; i < 5; i++)
            step(48'h0, 16'h0000, 0, 0, -30000, 1'b0, 1'b1, -30000, -100, "R7");
        // R7 full-scale baseband saturates z and the sum
        for (int i = 0; i < 16; i++)
            step(48'h1555_5555_5555, 16'h0000, 32767, 32767, 20000, 1'b1, 1'b0, 0, 0, "R7 R4");
        for (int i = 0; i < 16; i++)
            step(48'h1555_5555_5555, 16'h8000, -32768, -32768, -20000, 1'b1, 1'b0, 0, 0, "R7 R4");
        // R5 flush: the last functional vectors are compared three clocks late
        for (int i = 0; i < 3; i++)
            step(48'h0, 16'h0000, 0, 0, 0, 1'b0, 1'b0, 0, 0, "R5");
        done = 1'b1;
        finish_run();
    end

endmodule